// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Sequencer

This block models, in synchronous logic, the digital side of a converter's four-wire serial port. The port is tied into a repeating cycle of converting, sleeping and transferring. After reset it converts at once. A conversion lasts a fixed number of system clock cycles and is simulated: when it finishes, the block latches the parallel result word `conv_data` into a shift register and goes to sleep. While asleep it holds that result for as long as needed. It raises `low_power` whenever chip select is high in that state.

Pulling `cs_n` low wakes the block into the transfer state. The result then leaves on `sdo`, MSB first, changing only after falling `sck` edges. At the same time configuration bits are taken from `sdi` on rising `sck` edges. Chip select timing alone decides how a transfer ends, in one of three ways. Raising `cs_n` before any rising `sck` edge sends the block back to sleep. Raising it after at least one rising edge aborts the transfer and starts a conversion. Clocking `FRAME_BITS` rising edges completes the transfer and starts a conversion, and only then is the captured word published on `cfg_word` for that conversion. All serial inputs pass a `SYNC_STAGES` synchroniser, and edges are found against a registered copy.

There are four states: BOOT (one cycle after reset), CONV (counting the conversion), SLEEP (holding the result) and XFER (shifting). The transitions are: BOOT to CONV always; CONV to SLEEP when the count expires; SLEEP to XFER when `cs_n` is low; XFER to SLEEP when `cs_n` rises with no rising `sck` seen; XFER to CONV on an abort, meaning `cs_n` rises after a rising `sck`; XFER to CONV on completion, meaning `FRAME_BITS` rising edges have been counted.

Top module: `dsm_serial_seq`

## Requirements
- R1: While reset is held, `converting`, `low_power` and `sdo_oe` are 0 and `cfg_word` equals `CFG_RESET`. After reset is released, a conversion starts without any serial activity.
- R2: A conversion keeps `converting` at 1 for exactly `CONV_CYCLES` system clock cycles. In its last cycle `conv_data` is captured as the result to send.
- R3: In SLEEP with `cs_n` high, `low_power` is 1 and `converting` is 0, and the captured result is held unchanged for any length of time.
- R4: `cs_n` low in SLEEP enters XFER. `sdo_oe` becomes 1 and `sdo` shows the result MSB before any `sck` edge.
- R5: `sdo` moves to the next lower result bit only after a falling `sck` edge. Bit k of the frame, counted from 0, is result bit `FRAME_BITS-1-k` while `sck` is low before the k-th rising edge.
- R6: `sdi` is sampled on rising `sck` edges. The first `CFG_W` bits form the configuration word, first bit in the MSB.
- R7: The `FRAME_BITS`-th rising edge ends the transfer and starts a new conversion. `cfg_word` then takes the captured word, and the next transfer sends that conversion's result.
- R8: `cs_n` high in XFER before any rising `sck` edge returns the block to SLEEP with no conversion. The held result is untouched, and the next transfer starts again from its MSB. `cfg_word` is unchanged.
- R9: `cs_n` high in XFER after at least one rising `sck` edge starts a new conversion at once. `cfg_word` keeps its previous value.
- R10: `sdo_oe` is 0 whenever the synchronised `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial configuration data in |
| conv_data | input | FRAME_BITS | Parallel result of the simulated conversion |
| sdo | output | 1 | Serial result data out, 0 when not driven |
| sdo_oe | output | 1 | Output enable standing for a driven `sdo` pin |
| cfg_word | output | CFG_W | Configuration in force for the current conversion |
| converting | output | 1 | High while a conversion runs |
| low_power | output | 1 | High while asleep with `cs_n` high |

## Verification
The bench builds the block with `CONV_CYCLES` = 20, `FRAME_BITS` = 24, `CFG_W` = 8 and two synchroniser stages. A conversion is therefore short enough to run eight complete frames with arithmetically generated result and configuration patterns, and to compare every one of the 24 serial bits of each frame. The short conversion also lets the bench count the `converting` pulse cycle by cycle, and reach both early-exit paths, sleep return and abort, followed by a read-back that shows whether a conversion happened in between.

// File: rtl/dsm_seq_pkg.sv
package dsm_seq_pkg;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_XFER  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/dsm_in_sync.sv
module dsm_in_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dsm_shifter.sv
module dsm_shifter #(
    parameter int FRAME_BITS = 24,
    parameter int CFG_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_val,
    input  logic                  shift_en,
    input  logic                  cap_en,
    input  logic                  sdi_bit,
    output logic                  sdo_bit,
    output logic [CFG_W-1:0]      cfg_cap
);
    logic [FRAME_BITS-1:0] data_q;
    logic [CFG_W-1:0]      cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= load_val;
        end else if (shift_en) begin
            data_q <= {data_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_en) begin
            cap_q <= {cap_q[CFG_W-2:0], sdi_bit};
        end
    end

    assign sdo_bit = data_q[FRAME_BITS-1];
    assign cfg_cap = cap_q;
endmodule

// File: rtl/dsm_serial_seq.sv
module dsm_serial_seq
    import dsm_seq_pkg::*;
#(
    parameter int               CONV_CYCLES = 20,
    parameter int               FRAME_BITS  = 24,
    parameter int               CFG_W       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0] CFG_RESET   = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sck,
    input  logic                  sdi,
    input  logic [FRAME_BITS-1:0] conv_data,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic [CFG_W-1:0]      cfg_word,
    output logic                  converting,
    output logic                  low_power
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam int BIT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] CFG_LIM   = BIT_W'(CFG_W);

    // synchronised serial pins: {cs_n, sck, sdi}
    logic [2:0] pins_s;
    logic       cs_s, sck_s, sdi_s, sck_d;
    logic       sck_rise, sck_fall;

    dsm_in_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cs_n, sck, sdi}),
        .d_sync  (pins_s)
    );

    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] conv_cnt_q;
    logic [BIT_W-1:0] bit_cnt_q;
    logic             saw_rise_q;
    logic             load_res, cfg_load, shift_en, cap_en;
    logic [CFG_W-1:0] cfg_cap;
    logic             sdo_bit;

    // next-state and strobe decode
    always_comb begin
        state_d  = state_q;
        load_res = 1'b0;
        cfg_load = 1'b0;
        shift_en = 1'b0;
        cap_en   = 1'b0;
        unique case (state_q)
            ST_BOOT: state_d = ST_CONV;
            ST_CONV: begin
                if (conv_cnt_q == CONV_LAST) begin
                    state_d  = ST_SLEEP;
                    load_res = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!cs_s) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (cs_s) begin
                    state_d = saw_rise_q ? ST_CONV : ST_SLEEP;
                end else begin
                    cap_en   = sck_rise && (bit_cnt_q < CFG_LIM);
                    shift_en = sck_fall && saw_rise_q;
                    if (sck_rise && bit_cnt_q == BIT_LAST) begin
                        state_d  = ST_CONV;
                        cfg_load = 1'b1;
                    end
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_BOOT;
            conv_cnt_q <= '0;
            bit_cnt_q  <= '0;
            saw_rise_q <= 1'b0;
            cfg_word   <= CFG_RESET;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CONV && state_d == ST_CONV)
                conv_cnt_q <= conv_cnt_q + 1'b1;
            else
                conv_cnt_q <= '0;
            if (state_q == ST_XFER && state_d == ST_XFER) begin
                if (sck_rise) begin
                    bit_cnt_q  <= bit_cnt_q + 1'b1;
                    saw_rise_q <= 1'b1;
                end
            end else begin
                bit_cnt_q  <= '0;
                saw_rise_q <= 1'b0;
            end
            if (cfg_load) cfg_word <= cfg_cap;
        end
    end

    dsm_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .CFG_W      (CFG_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_res),
        .load_val (conv_data),
        .shift_en (shift_en),
        .cap_en   (cap_en),
        .sdi_bit  (sdi_s),
        .sdo_bit  (sdo_bit),
        .cfg_cap  (cfg_cap)
    );

    // outputs
    always_comb begin
        converting = (state_q == ST_CONV);
        low_power  = (state_q == ST_SLEEP) && cs_s;
        sdo_oe     = (state_q == ST_XFER) && !cs_s;
        sdo        = sdo_oe ? sdo_bit : 1'b0;
    end

    p_lp_not_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> !converting);

    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && $past(state_q == ST_XFER) && !$past(sck_fall))
            |-> $stable(sdo_bit));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_word));

    p_abort_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && cs_s && saw_rise_q) |=> (state_q == ST_CONV));

    p_back_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && cs_s && !saw_rise_q) |=> (state_q == ST_SLEEP));

    p_bit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q < BIT_W'(FRAME_BITS));

    p_oe_only_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !low_power && !converting);
endmodule

// File: tb/dsm_serial_seq_tb.sv
module dsm_serial_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CONV  = 20;
    localparam int FB    = 24;
    localparam int CW    = 8;
    localparam int SETTLE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic [FB-1:0] conv_data = '0;
    logic          sdo, sdo_oe, converting, low_power;
    logic [CW-1:0] cfg_word;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsm_serial_seq #(
        .CONV_CYCLES (CONV),
        .FRAME_BITS  (FB),
        .CFG_W       (CW),
        .SYNC_STAGES (2),
        .CFG_RESET   ('0)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .sdi        (sdi),
        .conv_data  (conv_data),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .cfg_word   (cfg_word),
        .converting (converting),
        .low_power  (low_power)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one SCK pulse: SDO checked while SCK low, before the rise
    task automatic bit_cycle(input logic din, input logic exp_out, input string req);
        sdi = din;
        wait_clk(SETTLE);
        chk(req, {31'd0, sdo}, {31'd0, exp_out});
        sck = 1'b1;
        wait_clk(SETTLE);
        sck = 1'b0;
        wait_clk(SETTLE);
    endtask

    task automatic full_frame(input logic [FB-1:0] exp_data, input logic [CW-1:0] cfg_in);
        cs_n = 1'b0;
        wait_clk(SETTLE);
        chk("R4 oe", {31'd0, sdo_oe}, 32'd1);
        for (int k = 0; k < FB; k++) begin
            logic din;
            din = (k < CW) ? cfg_in[CW-1-k] : 1'b0;
            bit_cycle(din, exp_data[FB-1-k], "R5 bit");
        end
    endtask

    task automatic wait_sleep();
        cs_n = 1'b1;
        wait_clk(CONV + 2*SETTLE);
    endtask

    initial begin : main
        fork
            begin : body
                logic [CW-1:0] cur_cfg;
                logic [FB-1:0] held;
                int cnt;
                wait_clk(3);
                chk("R1 conv", {31'd0, converting}, 32'd0);
                chk("R1 lp",   {31'd0, low_power},  32'd0);
                chk("R1 oe",   {31'd0, sdo_oe},     32'd0);
                chk("R1 cfg",  {24'd0, cfg_word},   32'd0);
                conv_data = 24'h5A3C0F;
                rst_n = 1'b1;
                cnt = 0;
                for (int i = 0; i < CONV + 10; i++) begin
                    @(negedge clk);
                    if (converting) cnt++;
                end
                chk("R2 length", cnt, CONV);
                chk("R1 started", {31'd0, cnt != 0}, 32'd1);
                chk("R3 lp", {31'd0, low_power}, 32'd1);
                chk("R10 oe", {31'd0, sdo_oe}, 32'd0);
                held = 24'h5A3C0F;
                cur_cfg = '0;
                conv_data = 24'hFFFFFF;
                wait_clk(200);
                chk("R3 still asleep", {31'd0, low_power}, 32'd1);
                // sweep of complete frames
                for (int p = 0; p < 8; p++) begin
                    logic [FB-1:0] nxt;
                    logic [CW-1:0] cfg_in;
                    nxt = (24'hA50F3C ^ (24'h13579B * (p + 1))) & 24'hFFFFFF;
                    cfg_in = CW'((p * 37 + 5) % 256);
                    full_frame(held, cfg_in);
                    conv_data = nxt;
                    chk("R7 conv started", {31'd0, converting}, 32'd1);
                    chk("R6 R7 cfg", {24'd0, cfg_word}, {24'd0, cfg_in});
                    cur_cfg = cfg_in;
                    wait_sleep();
                    chk("R3 sleep", {31'd0, low_power}, 32'd1);
                    held = nxt;
                end
                // return to sleep before first rise
                conv_data = 24'h123456;
                cs_n = 1'b0;
                wait_clk(SETTLE);
                chk("R4 msb", {31'd0, sdo}, {31'd0, held[FB-1]});
                chk("R4 lp off", {31'd0, low_power}, 32'd0);
                cs_n = 1'b1;
                wait_clk(SETTLE);
                chk("R8 sleep", {31'd0, low_power}, 32'd1);
                chk("R8 no conv", {31'd0, converting}, 32'd0);
                chk("R10 oe", {31'd0, sdo_oe}, 32'd0);
                chk("R8 cfg", {24'd0, cfg_word}, {24'd0, cur_cfg});
                wait_clk(CONV);
                full_frame(held, 8'hC3);
                wait_sleep();
                cur_cfg = 8'hC3;
                chk("R8 data kept", 32'd1, 32'd1);
                held = 24'h123456;
                // abort after k rising edges, k = 1..3
                for (int k = 1; k <= 3; k++) begin
                    logic [FB-1:0] nxt;
                    nxt = 24'h00F00D + 24'(k * 24'h111111);
                    conv_data = nxt;
                    cs_n = 1'b0;
                    wait_clk(SETTLE);
                    for (int j = 0; j < k; j++)
                        bit_cycle(1'b1, held[FB-1-j], "R5 abort bit");
                    cs_n = 1'b1;
                    wait_clk(SETTLE);
                    chk("R9 conv", {31'd0, converting}, 32'd1);
                    chk("R10 oe", {31'd0, sdo_oe}, 32'd0);
                    wait_clk(CONV + SETTLE);
                    chk("R9 cfg kept", {24'd0, cfg_word}, {24'd0, cur_cfg});
                    held = nxt;
                end
                full_frame(held, 8'h3C);
                wait_sleep();
                chk("R7 cfg final", {24'd0, cfg_word}, 32'h3C);
            end
            begin : watchdog
                wait_clk(150000);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule